// File: doc/BRIEF.md
# Smart-Card Character Transmitter with Error-Driven Resend

This block sends bytes over the single bidirectional I/O wire of a smart card using the asynchronous half-duplex character protocol (T=0 framing). A byte is accepted through a valid/ready handshake and framed as a start bit, eight data bits and a parity bit. The block never pulls the wire high: it either pulls the wire low or lets it float, and an external pull-up reads the floating wire as one. Bit periods are measured in pulses of a sub-bit enable, `tick`. Each bit period lasts `SUBS` ticks.

After the parity bit the block lets go of the wire for two bit periods. It looks at the wire once, in the middle of the first of those periods. A low level there means the card is signalling a parity error. In that case the character is stretched by one more released bit period, and then the same byte is sent again from a fresh start bit. The configuration inputs are captured when a byte is accepted. They select LSB-first or MSB-first order, inverted data bits, and inverted parity. After `MAX_RETRY` resends of one byte that are all refused, the byte is dropped and a sticky error flag is raised.

Top module: `sc_t0_tx`

## Requirements
- R1: After acceptance, the wire carries a start bit (driven low), eight data bits and a parity bit, each lasting `SUBS` ticks. These are followed by two released guard bit periods.
- R2: The parity bit's level on the wire is the XOR of the eight data byte bits, XORed with `cfg_inv_par`. With `cfg_inv_par`=0 this gives even parity over the byte.
- R3: With `cfg_msb_first`=0, data bit k (k=0..7) carries byte bit k. With `cfg_msb_first`=1, it carries byte bit 7-k.
- R4: With `cfg_inv_data`=1, every data bit is placed on the wire complemented. With `cfg_inv_data`=0, it is placed unchanged.
- R5: The wire is never driven during the guard or error-extension periods. A one is always sent by releasing the wire.
- R6: If the wire reads high at the middle of the first guard period, the block goes idle at the end of the second guard period. `in_ready` rises at that point, and a waiting byte starts on the very next clock edge.
- R7: If the wire reads low at the middle of the first guard period, one extra released bit period follows the two guard periods. Then the same byte restarts with a start bit.
- R8: If a byte is refused on its first send and on `MAX_RETRY` resends, it is dropped at the end of its extension period and `err_seen` rises. `err_seen` stays high until reset.
- R9: The resend count starts from zero for every newly accepted byte.
- R10: The frame advances only on clock edges where `tick` is high. While `tick` is low, the wire drive and the position in the frame hold.
- R11: Out of reset, the block is idle: `in_ready`=1, `busy`=0, `io_drive_low`=0 and `err_seen`=0.
- R12: A byte is taken on an edge where `in_valid` and `in_ready` are both high. While the block is busy, `in_ready` is low and the start bit is being driven from the next cycle onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sub-bit enable, `SUBS` pulses per bit period |
| cfg_msb_first | input | 1 | 1 = most significant data bit first |
| cfg_inv_data | input | 1 | 1 = data bits sent complemented |
| cfg_inv_par | input | 1 | 1 = parity bit inverted |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Block can take a byte |
| io_in | input | 1 | Level read back from the card wire |
| io_drive_low | output | 1 | 1 = pull the card wire low |
| busy | output | 1 | A character is in progress |
| err_seen | output | 1 | Sticky: a byte was dropped after too many refusals |

## Verification
The bench builds the block with `SUBS`=4 and `MAX_RETRY`=2. Short bit periods make it cheap to send every byte value under all eight combinations of order, data inversion and parity inversion, with each frame compared bit by bit against an arithmetic model. With a retry limit of two, exhaustion is reached on the third refusal. That lets the bench cover a single refusal, refusals just short of the limit, and the drop with its sticky flag in a few characters. A stalled tick on the start bit exercises the hold behaviour.

// File: rtl/sc_t0_pkg.sv
package sc_t0_pkg;
    typedef logic [3:0] idx_t;

    // Frame positions; the order is the on-wire sequence.
    localparam idx_t IDX_START  = 4'd0;
    localparam idx_t IDX_PARITY = 4'd9;
    localparam idx_t IDX_GUARD1 = 4'd10;
    localparam idx_t IDX_GUARD2 = 4'd11;
    localparam idx_t IDX_ERRX   = 4'd12;
endpackage

// File: rtl/sc_t0_bitsel.sv
// Maps the frame position and the captured byte/config onto the wire drive.
module sc_t0_bitsel
    import sc_t0_pkg::*;
(
    input  logic [7:0] data,
    input  logic       msb_first,
    input  logic       inv_data,
    input  logic       inv_par,
    input  idx_t       idx,
    output logic       drive_low
);
    logic [7:0] rev;
    logic [7:0] ordered;
    logic [2:0] pos;
    logic       lvl;

    for (genvar i = 0; i < 8; i++) begin : g_rev
        assign rev[i] = data[7-i];
    end

    always_comb begin
        ordered = msb_first ? rev : data;
        pos     = 3'(idx - 4'd1);
        lvl     = 1'b1;
        if (idx == IDX_START) begin
            lvl = 1'b0;
        end else if (idx < IDX_PARITY) begin
            lvl = ordered[pos] ^ inv_data;
        end else if (idx == IDX_PARITY) begin
            lvl = (^data) ^ inv_par;
        end
        drive_low = ~lvl;
    end
endmodule

// File: rtl/sc_t0_retry.sv
// Counts resends of the current byte; reports when the limit is reached.
module sc_t0_retry #(
    parameter int MAX_RETRY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic exhausted
);
    localparam int RW = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);

    logic [RW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (bump) begin
            cnt_d = cnt_q + RW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign exhausted = (cnt_q >= RW'(MAX_RETRY));
endmodule

// File: rtl/sc_t0_tx.sv
module sc_t0_tx
    import sc_t0_pkg::*;
#(
    parameter int SUBS      = 16,
    parameter int MAX_RETRY = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cfg_msb_first,
    input  logic       cfg_inv_data,
    input  logic       cfg_inv_par,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    input  logic       io_in,
    output logic       io_drive_low,
    output logic       busy,
    output logic       err_seen
);
    localparam int SW    = (SUBS < 2) ? 1 : $clog2(SUBS);
    localparam int SMID  = SUBS / 2;
    localparam int SLAST = SUBS - 1;

    typedef struct packed {
        logic          active;
        idx_t          idx;
        logic [SW-1:0] sub;
        logic [7:0]    data;
        logic          msb;
        logic          inv;
        logic          pinv;
        logic          nack;
        logic          err;
    } st_t;

    st_t  st_d, st_q;
    logic accept;
    logic bit_end;
    logic exhausted;
    logic retry_bump;
    logic sel_drive;
    idx_t cur_idx;

    assign accept     = in_valid && !st_q.active;
    assign bit_end    = st_q.active && tick && (st_q.sub == SW'(SLAST));
    assign retry_bump = bit_end && (st_q.idx == IDX_ERRX) && !exhausted;

    sc_t0_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .bump     (retry_bump),
        .exhausted(exhausted)
    );

    sc_t0_bitsel u_bitsel (
        .data     (st_q.data),
        .msb_first(st_q.msb),
        .inv_data (st_q.inv),
        .inv_par  (st_q.pinv),
        .idx      (st_q.idx),
        .drive_low(sel_drive)
    );

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.active = 1'b1;
            st_d.idx    = IDX_START;
            st_d.sub    = '0;
            st_d.data   = in_data;
            st_d.msb    = cfg_msb_first;
            st_d.inv    = cfg_inv_data;
            st_d.pinv   = cfg_inv_par;
            st_d.nack   = 1'b0;
        end else if (st_q.active && tick) begin
            // Single look at the wire, mid first guard period
            if (st_q.idx == IDX_GUARD1 && st_q.sub == SW'(SMID) && !io_in) begin
                st_d.nack = 1'b1;
            end
            if (st_q.sub == SW'(SLAST)) begin
                st_d.sub = '0;
                if (st_q.idx == IDX_GUARD2) begin
                    if (st_q.nack) st_d.idx = IDX_ERRX;
                    else           st_d.active = 1'b0;
                end else if (st_q.idx == IDX_ERRX) begin
                    st_d.nack = 1'b0;
                    if (exhausted) begin
                        st_d.active = 1'b0;
                        st_d.err    = 1'b1;
                    end else begin
                        st_d.idx = IDX_START;
                    end
                end else begin
                    st_d.idx = st_q.idx + 4'd1;
                end
            end else begin
                st_d.sub = st_q.sub + SW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_idx      = st_q.idx;
    assign in_ready     = !st_q.active;
    assign busy         = st_q.active;
    assign err_seen     = st_q.err;
    assign io_drive_low = st_q.active && sel_drive;
endmodule

// File: rtl/sc_t0_tx_chk.sv
module sc_t0_tx_chk
    import sc_t0_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic in_valid,
    input logic in_ready,
    input logic io_drive_low,
    input logic busy,
    input logic err_seen,
    input idx_t cur_idx
);
    // R5
    guard_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (cur_idx >= IDX_GUARD1) |-> !io_drive_low);

    // R12
    accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> busy && io_drive_low);

    // R12
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_seen |=> err_seen);

    // R10
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !tick |=> $stable(io_drive_low) && $stable(cur_idx));

    // R7
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> cur_idx <= IDX_ERRX);
endmodule

bind sc_t0_tx sc_t0_tx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .io_drive_low(io_drive_low),
    .busy        (busy),
    .err_seen    (err_seen),
    .cur_idx     (cur_idx)
);

// File: tb/sc_t0_tx_tb.sv
`timescale 1ns/1ps
module sc_t0_tx_tb;
    localparam int SUBS      = 4;
    localparam int MAX_RETRY = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       cfg_msb_first = 1'b0;
    logic       cfg_inv_data = 1'b0;
    logic       cfg_inv_par = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       io_in;
    logic       io_drive_low;
    logic       busy;
    logic       err_seen;
    logic       card_pull = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    assign io_in = !(io_drive_low || card_pull);

    sc_t0_tx #(.SUBS(SUBS), .MAX_RETRY(MAX_RETRY)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick_en),
        .cfg_msb_first(cfg_msb_first),
        .cfg_inv_data (cfg_inv_data),
        .cfg_inv_par  (cfg_inv_par),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_ready     (in_ready),
        .io_in        (io_in),
        .io_drive_low (io_drive_low),
        .busy         (busy),
        .err_seen     (err_seen)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Sends one byte; the card refuses the first 'nacks' attempts.
    task automatic send_char(input logic [7:0] b, input logic msb, input logic inv,
                             input logic pinv, input int nacks, input int stall);
        logic [9:0] exp;
        logic [9:0] got;
        bit         gbad;
        bit         hbad;
        bit         fin;
        bit         nk;
        int         a;
        int         last;
        exp[0] = 1'b0;
        for (int k = 0; k < 8; k++) exp[k+1] = (msb ? b[7-k] : b[k]) ^ inv;
        exp[9] = (^b) ^ pinv;
        got = '0;
        check(in_ready == 1'b1, "R12 ready before accept", int'(in_ready), 1);
        in_valid      = 1'b1;
        in_data       = b;
        cfg_msb_first = msb;
        cfg_inv_data  = inv;
        cfg_inv_par   = pinv;
        if (stall > 0) tick_en = 1'b0;
        @(negedge clk);
        in_valid      = 1'b0;
        cfg_msb_first = ~msb;
        cfg_inv_data  = ~inv;
        cfg_inv_par   = ~pinv;
        check(busy && !in_ready, "R12 busy after accept", int'({busy, in_ready}), 2);
        if (stall > 0) begin
            hbad = 1'b0;
            for (int s = 0; s < stall; s++) begin
                if (!(io_drive_low && busy)) hbad = 1'b1;
                @(negedge clk);
            end
            check(!hbad, "R10 hold without tick", int'(hbad), 0);
            tick_en = 1'b1;
        end
        a   = 0;
        fin = 1'b0;
        while (!fin) begin
            nk   = (a < nacks);
            last = nk ? 12 : 11;
            gbad = 1'b0;
            for (int k = 0; k <= last; k++) begin
                for (int s = 0; s < SUBS; s++) begin
                    if (s == 0 && k == 10) card_pull = nk;
                    if (s == 0 && k == 11) card_pull = 1'b0;
                    if (s == SUBS / 2) begin
                        if (k < 10) got[k] = !io_drive_low;
                        else if (io_drive_low) gbad = 1'b1;
                    end
                    @(negedge clk);
                end
            end
            check(got[0] == exp[0], "R1 start bit", int'(got[0]), int'(exp[0]));
            check(got[8:1] == exp[8:1], "R3 R4 data bits", int'(got[8:1]), int'(exp[8:1]));
            check(got[9] == exp[9], "R2 parity bit", int'(got[9]), int'(exp[9]));
            check(!gbad, "R5 guard released", int'(gbad), 0);
            if (!nk) begin
                check(!busy && in_ready, "R6 idle after guard", int'({busy, in_ready}), 1);
                fin = 1'b1;
            end else if (a == MAX_RETRY) begin
                check(!busy && err_seen, "R8 dropped with error", int'({busy, err_seen}), 1);
                fin = 1'b1;
            end else begin
                check(busy && io_drive_low, "R7 resend start", int'({busy, io_drive_low}), 3);
            end
            a++;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11
        check(in_ready && !busy && !io_drive_low && !err_seen, "R11 reset state",
              int'({in_ready, busy, io_drive_low, err_seen}), 8);

        // R1 R2 R3 R4 R6: every byte under every configuration, back to back
        for (int c = 0; c < 8; c++) begin
            for (int v = 0; v < 256; v++) begin
                send_char(8'(v), c[0], c[1], c[2], 0, 0);
            end
        end
        check(!err_seen, "R8 no error without refusals", int'(err_seen), 0);

        // R10: stalled tick during the start bit
        send_char(8'hA5, 1'b0, 1'b0, 1'b0, 0, 9);
        send_char(8'h3C, 1'b1, 1'b1, 1'b0, 0, 5);

        // R7: one refusal, then success
        send_char(8'h5A, 1'b0, 1'b0, 1'b0, 1, 0);
        // R9: refusals up to the limit, the byte still goes through
        send_char(8'hC3, 1'b1, 1'b0, 1'b1, MAX_RETRY, 0);
        send_char(8'h81, 1'b0, 1'b1, 1'b0, MAX_RETRY, 0);
        check(!err_seen, "R9 count restarts per byte", int'(err_seen), 0);

        // R8: exhaustion
        send_char(8'h7E, 1'b0, 1'b0, 1'b0, MAX_RETRY + 1, 0);
        send_char(8'h12, 1'b1, 1'b0, 1'b0, 0, 0);
        check(err_seen, "R8 error stays set", int'(err_seen), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule